// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition and system flags of a small 8-bit processor core. Every cycle it may take one ALU operation, and the operation's class decides which flags it loads. An addition or subtraction loads zero, carry, half carry and signed overflow. A rotate through carry loads only the carry. A logic operation loads only the zero flag.

The arithmetic flags are derived inside the block from the two operands. Only the zero flag is taken from the result the ALU reports. On a subtraction the carry holds the inverse of the borrow.

Software can overwrite the four arithmetic flags through a narrow write port. The two system flags, sleep (power-down) and watchdog-expired (time-out), have no write path at all. They move only on four system strobes: power-up, watchdog clear, halt and watchdog time-out. The block does not push itself anywhere on an interrupt or a call. Saving the register is left to software.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rstN` is low, `statusOut` reads 0x00. The layout is: bit0 carry, bit1 half carry, bit2 zero, bit3 overflow, bit4 sleep, bit5 watchdog-expired, bits 7:6 unused.
- R2: On an addition (`aluValid`=1, `aluOp`=0, no write):
  - carry takes the carry out of `opA+opB`;
  - half carry takes the carry out of bit 3;
  - overflow is set when the carry into bit 7 differs from the carry out of bit 7.
- R3: On a subtraction `opA-opB` (`aluOp`=1, no write):
  - carry is 1 exactly when no borrow occurs (`opA>=opB` unsigned);
  - half carry is 1 when the low nibble needs no borrow;
  - overflow is set when the signed difference does not fit in 8 bits.
- R4: On an addition, a subtraction or a logic operation, zero is set exactly when `aluResult` is 0x00.
- R5: A logic operation (`aluOp`=3) leaves carry, half carry and overflow unchanged.
- R6: A rotate through carry (`aluOp`=2) loads carry with `opA[7]` when `rotLeft`=1 and with `opA[0]` when `rotLeft`=0. It leaves zero, half carry and overflow unchanged.
- R7: A software write (`wrEn`=1) loads bits 3:0 from `wrData`. The write takes priority over any ALU operation in the same cycle. It never changes bits 5:4.
- R8: The watchdog-expired flag is handled as follows:
  - `powerUp`, `clrWdt` and `halt` each clear it;
  - `wdtTimeout` sets it;
  - when the time-out coincides with a clear or a halt, the time-out wins;
  - `powerUp` overrides everything.
- R9: The sleep flag is set by `halt` and cleared by `powerUp` or `clrWdt`. A clear wins over a coincident halt.
- R10: Bits 7:6 of `statusOut` always read 0.
- R11: With no ALU operation, no write and no system strobe, `statusOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, clears all flags |
| aluValid | input | 1 | An ALU operation completes this cycle |
| aluOp | input | 2 | Operation class: 0 add, 1 subtract, 2 rotate through carry, 3 logic |
| opA | input | 8 | First ALU operand (minuend on subtraction, rotated value) |
| opB | input | 8 | Second ALU operand (subtrahend on subtraction) |
| aluResult | input | 8 | Result reported by the ALU, used for the zero flag |
| rotLeft | input | 1 | Rotate direction: 1 left, 0 right |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 4 | New values for bits 3:0 |
| powerUp | input | 1 | Power-up event strobe |
| clrWdt | input | 1 | Watchdog clear instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| wdtTimeout | input | 1 | Watchdog time-out strobe |
| statusOut | output | 8 | Register value |

## Verification
Directed operand pairs separate the flags from one another:
- 0x80+0x80 gives carry and overflow together with a zero result;
- 0x0F+0x01 gives a half carry alone;
- 0x7F+0x01 gives overflow without carry;
- 0x00-0x01, 0x10-0x01 and 0x80-0x01 tell the borrow, nibble-borrow and signed-overflow rules apart.

Coincident strobe pairs pin down the priorities: time-out with clear, halt with clear, power-up with time-out, and a write together with an ALU operation. Random operands across all four classes, with sparse system strobes, compare every field against an independent model each cycle. Idle cycles confirm that nothing drifts.

// File: rtl/status_pkg.sv
package status_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_ROT   = 2'd2,
    OP_LOGIC = 2'd3
  } aluOp_e;

  localparam int STATUS_W = 8;
  localparam int SW_W     = 4;
  localparam int BIT_C    = 0;
  localparam int BIT_AC   = 1;
  localparam int BIT_Z    = 2;
  localparam int BIT_OV   = 3;
  localparam int BIT_PDF  = 4;
  localparam int BIT_TO   = 5;

  typedef struct packed {
    logic arithLoad;
    logic subMode;
    logic rotLoad;
    logic zeroLoad;
    logic swLoad;
    logic toSet;
    logic toClr;
    logic pdfSet;
    logic pdfClr;
  } flagStrobe_t;

endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aluValid,
  input  logic [1:0]  aluOp,
  input  logic        wrEn,
  input  logic        powerUp,
  input  logic        clrWdt,
  input  logic        halt,
  input  logic        wdtTimeout,
  output flagStrobe_t strb
);

  always_comb begin
    strb = '0;
    strb.swLoad = wrEn;
    if (aluValid && !wrEn) begin
      case (aluOp_e'(aluOp))
        OP_ADD:   begin strb.arithLoad = 1'b1; strb.zeroLoad = 1'b1; end
        OP_SUB:   begin strb.arithLoad = 1'b1; strb.subMode = 1'b1; strb.zeroLoad = 1'b1; end
        OP_ROT:   strb.rotLoad = 1'b1;
        default:  strb.zeroLoad = 1'b1;
      endcase
    end
    // watchdog-expired: power-up overrides, time-out beats clear/halt
    strb.toSet  = wdtTimeout && !powerUp;
    strb.toClr  = powerUp || ((clrWdt || halt) && !wdtTimeout);
    // sleep: clear beats a coincident halt
    strb.pdfClr = powerUp || clrWdt;
    strb.pdfSet = halt && !(powerUp || clrWdt);
  end

  assert_write_over_alu_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !(strb.arithLoad || strb.rotLoad || strb.zeroLoad));

  assert_to_timeout_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wdtTimeout && !powerUp) |-> (strb.toSet && !strb.toClr));

  assert_pdf_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pdfSet && strb.pdfClr));

  assert_logic_only_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && !wrEn && aluOp == 2'd3) |-> (strb.zeroLoad && !strb.arithLoad && !strb.rotLoad));

endmodule

// File: rtl/status_dp.sv
module status_dp
  import status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NIBBLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobe_t         strb,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   aluResult,
  input  logic                rotLeft,
  input  logic [SW_W-1:0]     wrData,
  output logic [STATUS_W-1:0] statusOut
);

  logic [DATA_W-1:0]   bEff;
  logic [NIBBLE_W:0]   lowSum;
  logic [DATA_W-1:0]   topSum;
  logic [DATA_W:0]     fullSum;
  logic                carryNext, halfNext, ovNext, zeroNext, rotBit;
  logic                cFlag, acFlag, zFlag, ovFlag, pdfFlag, toFlag;

  // subtraction is a + ~b + 1, so carry out equals "no borrow"
  always_comb begin
    bEff    = strb.subMode ? ~opB : opB;
    lowSum  = {1'b0, opA[NIBBLE_W-1:0]} + {1'b0, bEff[NIBBLE_W-1:0]}
            + {{NIBBLE_W{1'b0}}, strb.subMode};
    topSum  = {1'b0, opA[DATA_W-2:0]} + {1'b0, bEff[DATA_W-2:0]}
            + {{(DATA_W-1){1'b0}}, strb.subMode};
    fullSum = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, strb.subMode};
    carryNext = fullSum[DATA_W];
    halfNext  = lowSum[NIBBLE_W];
    ovNext    = topSum[DATA_W-1] ^ fullSum[DATA_W];
    zeroNext  = ~|aluResult;
    rotBit    = rotLeft ? opA[DATA_W-1] : opA[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cFlag  <= 1'b0;
      acFlag <= 1'b0;
      zFlag  <= 1'b0;
      ovFlag <= 1'b0;
    end else if (strb.swLoad) begin
      cFlag  <= wrData[BIT_C];
      acFlag <= wrData[BIT_AC];
      zFlag  <= wrData[BIT_Z];
      ovFlag <= wrData[BIT_OV];
    end else begin
      if (strb.arithLoad) begin
        cFlag  <= carryNext;
        acFlag <= halfNext;
        ovFlag <= ovNext;
      end
      if (strb.rotLoad)  cFlag <= rotBit;
      if (strb.zeroLoad) zFlag <= zeroNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag  <= 1'b0;
      pdfFlag <= 1'b0;
    end else begin
      if (strb.toSet)       toFlag <= 1'b1;
      else if (strb.toClr)  toFlag <= 1'b0;
      if (strb.pdfClr)      pdfFlag <= 1'b0;
      else if (strb.pdfSet) pdfFlag <= 1'b1;
    end
  end

  always_comb begin
    statusOut          = '0;
    statusOut[BIT_C]   = cFlag;
    statusOut[BIT_AC]  = acFlag;
    statusOut[BIT_Z]   = zFlag;
    statusOut[BIT_OV]  = ovFlag;
    statusOut[BIT_PDF] = pdfFlag;
    statusOut[BIT_TO]  = toFlag;
  end

  assert_write_keeps_sys_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swLoad && !strb.toSet && !strb.toClr && !strb.pdfSet && !strb.pdfClr)
      |=> $stable(statusOut[BIT_TO:BIT_PDF]));

  assert_timeout_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.toSet |=> statusOut[BIT_TO]);

  assert_halt_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.pdfSet |=> statusOut[BIT_PDF]);

  assert_logic_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.zeroLoad && !strb.arithLoad && !strb.swLoad)
      |=> ($stable(statusOut[BIT_C]) && $stable(statusOut[BIT_AC]) && $stable(statusOut[BIT_OV])));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(statusOut));

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NIBBLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                aluValid,
  input  logic [1:0]          aluOp,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   aluResult,
  input  logic                rotLeft,
  input  logic                wrEn,
  input  logic [SW_W-1:0]     wrData,
  input  logic                powerUp,
  input  logic                clrWdt,
  input  logic                halt,
  input  logic                wdtTimeout,
  output logic [STATUS_W-1:0] statusOut
);

  flagStrobe_t strb;

  status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .aluOp(aluOp), .wrEn(wrEn),
    .powerUp(powerUp), .clrWdt(clrWdt), .halt(halt), .wdtTimeout(wdtTimeout),
    .strb(strb)
  );

  status_dp #(.DATA_W(DATA_W), .NIBBLE_W(NIBBLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .aluResult(aluResult), .rotLeft(rotLeft), .wrData(wrData),
    .statusOut(statusOut)
  );

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7:6] == 2'b00);

endmodule

// File: tb/sim_cpu_status_reg.sv
`timescale 1ns/1ps
module sim_cpu_status_reg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       aluValid = 1'b0;
  logic [1:0] aluOp = 2'd0;
  logic [7:0] opA = 8'd0, opB = 8'd0, aluResult = 8'd0;
  logic       rotLeft = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrData = 4'd0;
  logic       powerUp = 1'b0, clrWdt = 1'b0, halt = 1'b0, wdtTimeout = 1'b0;
  logic [7:0] statusOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expSt = 8'd0;

  always #2 clk = ~clk;

  cpu_status_reg u0 (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .aluOp(aluOp), .opA(opA),
    .opB(opB), .aluResult(aluResult), .rotLeft(rotLeft), .wrEn(wrEn),
    .wrData(wrData), .powerUp(powerUp), .clrWdt(clrWdt), .halt(halt),
    .wdtTimeout(wdtTimeout), .statusOut(statusOut)
  );

  // Reference model written from the requirements
  function automatic logic [7:0] modelNext(input logic [7:0] cur);
    logic [7:0] n = cur;
    logic [8:0] s;
    logic [7:0] d;
    if (wrEn) n[3:0] = wrData;
    else if (aluValid) begin
      case (aluOp)
        2'd0: begin
          s = {1'b0, opA} + {1'b0, opB};
          n[0] = s[8];
          n[1] = ({1'b0, opA[3:0]} + {1'b0, opB[3:0]}) > 5'd15;
          n[3] = (opA[7] == opB[7]) && (s[7] != opA[7]);
          n[2] = (aluResult == 8'd0);
        end
        2'd1: begin
          d = opA - opB;
          n[0] = (opA >= opB);
          n[1] = (opA[3:0] >= opB[3:0]);
          n[3] = (opA[7] != opB[7]) && (d[7] != opA[7]);
          n[2] = (aluResult == 8'd0);
        end
        2'd2: n[0] = rotLeft ? opA[7] : opA[0];
        default: n[2] = (aluResult == 8'd0);
      endcase
    end
    if (powerUp) n[5] = 1'b0;
    else if (wdtTimeout) n[5] = 1'b1;
    else if (clrWdt || halt) n[5] = 1'b0;
    if (powerUp || clrWdt) n[4] = 1'b0;
    else if (halt) n[4] = 1'b1;
    n[7:6] = 2'b00;
    return n;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    string lowTag;
    string zTag;
    @(posedge clk);
    expSt = modelNext(expSt);
    #1;
    if (wrEn) lowTag = "R7";
    else if (!aluValid) lowTag = "R11";
    else case (aluOp)
      2'd0: lowTag = "R2";
      2'd1: lowTag = "R3";
      2'd2: lowTag = "R6";
      default: lowTag = "R5";
    endcase
    zTag = (aluValid && !wrEn && aluOp != 2'd2) ? "R4" : lowTag;
    chk(lowTag, "C/AC/OV", {5'd0, statusOut[3], statusOut[1:0]}, {5'd0, expSt[3], expSt[1:0]});
    chk(zTag, "Z", {7'd0, statusOut[2]}, {7'd0, expSt[2]});
    chk("R8", "TO", {7'd0, statusOut[5]}, {7'd0, expSt[5]});
    chk("R9", "PDF", {7'd0, statusOut[4]}, {7'd0, expSt[4]});
    chk("R10", "upper", {6'd0, statusOut[7:6]}, 8'd0);
  endtask

  task automatic clearIn();
    aluValid = 0; wrEn = 0; powerUp = 0; clrWdt = 0; halt = 0; wdtTimeout = 0;
  endtask

  task automatic doAlu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
    clearIn();
    aluValid = 1; aluOp = op; opA = a; opB = b;
    case (op)
      2'd0: aluResult = a + b;
      2'd1: aluResult = a - b;
      2'd2: aluResult = rotLeft ? {a[6:0], expSt[0]} : {expSt[0], a[7:1]};
      default: aluResult = a & b;
    endcase
    step();
  endtask

  task automatic doSys(input logic pu, input logic cw, input logic hl, input logic wt);
    clearIn();
    powerUp = pu; clrWdt = cw; halt = hl; wdtTimeout = wt;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "reset value", statusOut, 8'h00);
    @(negedge clk);
    rstN = 1;
    // R2 corners
    doAlu(2'd0, 8'h80, 8'h80);
    doAlu(2'd0, 8'h0F, 8'h01);
    doAlu(2'd0, 8'h7F, 8'h01);
    // R3 corners
    doAlu(2'd1, 8'h05, 8'h05);
    doAlu(2'd1, 8'h00, 8'h01);
    doAlu(2'd1, 8'h10, 8'h01);
    doAlu(2'd1, 8'h80, 8'h01);
    // R5 logic keeps C/AC/OV; R6 rotate
    doAlu(2'd3, 8'hF0, 8'h0F);
    rotLeft = 1; doAlu(2'd2, 8'h80, 8'h00);
    rotLeft = 0; doAlu(2'd2, 8'h02, 8'h00);
    // R8 / R9 priorities
    doSys(0, 0, 1, 0);
    doSys(0, 1, 0, 1);
    doSys(0, 0, 1, 1);
    doSys(0, 1, 1, 0);
    doSys(1, 0, 0, 1);
    doSys(0, 0, 0, 1);
    // R7 write keeps TO, beats ALU
    clearIn(); wrEn = 1; wrData = 4'hF; step();
    clearIn(); wrEn = 1; wrData = 4'h0; aluValid = 1; aluOp = 2'd0;
    opA = 8'hFF; opB = 8'h01; aluResult = 8'h00; step();
    // R11 idle
    clearIn(); repeat (3) step();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      clearIn();
      rotLeft = 1'($urandom);
      if ($urandom_range(9) == 0) begin
        wrEn = 1; wrData = 4'($urandom);
      end
      if ($urandom_range(3) != 0) begin
        aluValid = 1; aluOp = 2'($urandom); opA = 8'($urandom); opB = 8'($urandom);
        aluResult = (aluOp == 2'd0) ? opA + opB : (aluOp == 2'd1) ? opA - opB : (opA & opB);
        if ($urandom_range(7) == 0) aluResult = 8'd0;
      end
      powerUp    = ($urandom_range(31) == 0);
      clrWdt     = ($urandom_range(7) == 0);
      halt       = ($urandom_range(7) == 0);
      wdtTimeout = ($urandom_range(7) == 0);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule